// File: doc/BRIEF.md
# System clock source and ratio selector with wake-up reload

This block holds the control word that picks which of four clock sources drives the system and by how much that source is divided. Software writes a 16-bit word while an unlock input is high. Besides the active source and ratio fields, the word carries a second source and ratio pair and an enable bit. When the enable bit is set and the chip leaves sleep, the block copies that second pair into the active fields by itself.

Each source arrives as a one-cycle tick on the core clock, once per source period, together with a ready flag. The block asks for a source to run whenever that source is chosen or still in use. This starts a stopped source as soon as it is selected. The block keeps the old source running until the new one reports ready. It then divides the ticks of the source in use and gives out a one-cycle clock-enable pulse. The legal ratios depend on the source. A ratio code that has no meaning for the chosen source falls back to 1/1 and raises a one-cycle error flag.

Top module: `sysclk_sel`

## Requirements
- R1: The control word reads back as: bit 15 reload enable, bits 13:12 reload ratio code, bits 9:8 reload source code, bits 5:4 active ratio code, bits 1:0 active source code. Bits 14, 11:10, 7:6 and 3:2 always read 0.
- R2: After reset the control word reads 0x0020 (active ratio code 2, all else 0), the source in use is 0 and `div_err` is low.
- R3: A write (`reg_wr` high) updates the word at the clock edge only when `wr_unlock` is high. Otherwise the word is unchanged.
- R4: With bit 15 set, a cycle with both `sleep_in` and `wake_evt` high copies bits 9:8 into bits 1:0 and bits 13:12 into bits 5:4 at that edge.
- R5: With bit 15 clear, or with `sleep_in` low, `wake_evt` leaves the word unchanged.
- R6: When a reload and an unlocked write fall in the same cycle, the reload is applied and the written value is discarded entirely.
- R7: Source codes are 0 internal, 1 low-speed, 2 high-speed and 3 external. Ratio codes 0..3 give 1/1, 1/2, 1/4 and 1/8 for source 0. They give 1/1 and 1/2 for source 1 (codes 0 and 1 only) and 1/1, 1/2, 1/8 and 1/16 for source 2. Source 3 allows only code 0, which gives 1/1.
- R8: A ratio code that R7 leaves undefined for the selected source divides by 1. `div_err` is high for the single cycle after the edge that stores such a pair, through a write or a reload.
- R9: `src_req[i]` is high whenever the active source field or the source in use equals i. Selecting a stopped source therefore requests it at once.
- R10: The source in use changes to the active source only once `src_ready` of that source is high, and it does so at the first edge where that holds. Until then the previous source and its ratio stay in use.
- R11: `clk_en_out` pulses for one cycle, one cycle after every Nth tick of the source in use, where N is the ratio in effect. The count restarts whenever the source in use or its ratio changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write request for the control word |
| wr_unlock | input | 1 | Write permission; writes are dropped while low |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current control word |
| sleep_in | input | 1 | High while the chip is asleep |
| wake_evt | input | 1 | Wake-up event pulse |
| src_tick | input | 4 | One-cycle tick per period of each source |
| src_ready | input | 4 | Source is running and stable |
| src_req | output | 4 | Run request per source |
| use_src | output | 2 | Source currently driving the divider |
| div_err | output | 1 | One-cycle flag for an undefined ratio code |
| clk_en_out | output | 1 | Divided clock-enable pulse |

## Verification
The bench builds the block with the package defaults, where the largest shift is 4. This makes the 1/16 ratio of the high-speed source reachable, so the 4-bit counter wraps at its full range. The four source ticks run at periods of 2, 5, 1 and 3 core cycles. Each ratio therefore shows up as a distinct gap between pulses. The bench holds a source not ready, so the pending-switch case stays visible for as long as it chooses.

// File: rtl/sysclk_sel_pkg.sv
package sysclk_sel_pkg;
  localparam int NSRC   = 4;
  localparam int SRC_W  = $clog2(NSRC);
  localparam int DIV_W  = 2;
  localparam int WORD_W = 16;
  localparam int MAX_SH = 4;
  localparam int SH_W   = $clog2(MAX_SH + 1);
  localparam int CNT_W  = MAX_SH;

  typedef enum logic [SRC_W-1:0] {
    SRC_INT  = 2'd0,
    SRC_LOW  = 2'd1,
    SRC_HIGH = 2'd2,
    SRC_EXT  = 2'd3
  } src_e;

  typedef struct packed {
    logic             rl_en;
    logic [DIV_W-1:0] rl_div;
    logic [SRC_W-1:0] rl_src;
    logic [DIV_W-1:0] act_div;
    logic [SRC_W-1:0] act_src;
  } cfg_t;

  function automatic logic is_reserved(input logic [SRC_W-1:0] s,
                                       input logic [DIV_W-1:0] d);
    case (src_e'(s))
      SRC_LOW: is_reserved = (d > 2'd1);
      SRC_EXT: is_reserved = (d != 2'd0);
      default: is_reserved = 1'b0;
    endcase
  endfunction

  function automatic logic [SH_W-1:0] ratio_sh(input logic [SRC_W-1:0] s,
                                               input logic [DIV_W-1:0] d);
    if (is_reserved(s, d)) begin
      ratio_sh = '0;
    end else if (src_e'(s) == SRC_HIGH && d > 2'd1) begin
      ratio_sh = SH_W'(d) + SH_W'(1);
    end else begin
      ratio_sh = SH_W'(d);
    end
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input cfg_t c);
    pack_word = '0;
    pack_word[15]    = c.rl_en;
    pack_word[13:12] = c.rl_div;
    pack_word[9:8]   = c.rl_src;
    pack_word[5:4]   = c.act_div;
    pack_word[1:0]   = c.act_src;
  endfunction

  function automatic cfg_t unpack_word(input logic [WORD_W-1:0] w);
    unpack_word.rl_en   = w[15];
    unpack_word.rl_div  = w[13:12];
    unpack_word.rl_src  = w[9:8];
    unpack_word.act_div = w[5:4];
    unpack_word.act_src = w[1:0];
  endfunction
endpackage

// File: rtl/sysclk_cfg_reg.sv
module sysclk_cfg_reg
  import sysclk_sel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              wr_unlock,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              sleep_in,
  input  logic              wake_evt,
  output cfg_t              cfg,
  output logic [WORD_W-1:0] rdata,
  output logic              wake_load,
  output logic              wr_take,
  output logic              div_err
);
  cfg_t cfg_nxt;
  cfg_t cfg_rst;

  assign wake_load = sleep_in & wake_evt & cfg.rl_en;
  assign wr_take   = reg_wr & wr_unlock & ~wake_load;

  always_comb begin
    cfg_rst         = '0;
    cfg_rst.act_div = 2'd2;
    cfg_nxt         = cfg;
    if (wake_load) begin
      cfg_nxt.act_src = cfg.rl_src;
      cfg_nxt.act_div = cfg.rl_div;
    end else if (wr_take) begin
      cfg_nxt = unpack_word(reg_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= cfg_rst;
      div_err <= 1'b0;
    end else begin
      cfg     <= cfg_nxt;
      div_err <= (wake_load | wr_take) & is_reserved(cfg_nxt.act_src, cfg_nxt.act_div);
    end
  end

  assign rdata = pack_word(cfg);
endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch
  import sysclk_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] act_src,
  input  logic [DIV_W-1:0] act_div,
  input  logic [NSRC-1:0]  src_ready,
  output logic [SRC_W-1:0] use_src,
  output logic [SH_W-1:0]  use_sh,
  output logic             restart,
  output logic [NSRC-1:0]  src_req
);
  logic             tgt_ok;
  logic [SRC_W-1:0] src_nxt;
  logic [SH_W-1:0]  sh_nxt;

  assign tgt_ok  = (act_src == use_src) | src_ready[act_src];
  assign src_nxt = tgt_ok ? act_src : use_src;
  assign sh_nxt  = tgt_ok ? ratio_sh(act_src, act_div) : use_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      use_src <= SRC_INT;
      use_sh  <= ratio_sh(SRC_INT, 2'd2);
      restart <= 1'b0;
    end else begin
      use_src <= src_nxt;
      use_sh  <= sh_nxt;
      restart <= (src_nxt != use_src) | (sh_nxt != use_sh);
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_req
    assign src_req[i] = (act_src == SRC_W'(i)) | (use_src == SRC_W'(i));
  end
endmodule

// File: rtl/sysclk_div.sv
module sysclk_div
  import sysclk_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_tick,
  input  logic [SRC_W-1:0] use_src,
  input  logic [SH_W-1:0]  use_sh,
  input  logic             restart,
  output logic             sel_tick,
  output logic             clk_en_out
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign sel_tick = src_tick[use_src];
  assign lim      = (CNT_W'(1) << use_sh) - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      clk_en_out <= 1'b0;
    end else if (restart) begin
      cnt        <= '0;
      clk_en_out <= 1'b0;
    end else if (sel_tick) begin
      if (cnt == lim) begin
        cnt        <= '0;
        clk_en_out <= 1'b1;
      end else begin
        cnt        <= cnt + CNT_W'(1);
        clk_en_out <= 1'b0;
      end
    end else begin
      clk_en_out <= 1'b0;
    end
  end
endmodule

// File: rtl/sysclk_sel.sv
module sysclk_sel
  import sysclk_sel_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        wr_unlock,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        sleep_in,
  input  logic        wake_evt,
  input  logic [3:0]  src_tick,
  input  logic [3:0]  src_ready,
  output logic [3:0]  src_req,
  output logic [1:0]  use_src,
  output logic        div_err,
  output logic        clk_en_out
);
  cfg_t            cfg;
  logic            wake_load;
  logic            wr_take;
  logic [SH_W-1:0] use_sh;
  logic            restart;
  logic            sel_tick;

  sysclk_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .wr_unlock(wr_unlock),
    .reg_wdata(reg_wdata), .sleep_in(sleep_in), .wake_evt(wake_evt),
    .cfg(cfg), .rdata(reg_rdata), .wake_load(wake_load), .wr_take(wr_take),
    .div_err(div_err)
  );

  sysclk_switch u_sw (
    .clk(clk), .rst_n(rst_n), .act_src(cfg.act_src), .act_div(cfg.act_div),
    .src_ready(src_ready), .use_src(use_src), .use_sh(use_sh),
    .restart(restart), .src_req(src_req)
  );

  sysclk_div u_div (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .use_src(use_src),
    .use_sh(use_sh), .restart(restart), .sel_tick(sel_tick),
    .clk_en_out(clk_en_out)
  );
endmodule

// File: rtl/sysclk_sel_chk.sv
module sysclk_sel_chk
  import sysclk_sel_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        wr_unlock,
  input logic        sleep_in,
  input logic        wake_evt,
  input logic [15:0] reg_rdata,
  input logic [3:0]  src_ready,
  input logic [3:0]  src_req,
  input logic [1:0]  use_src,
  input logic        div_err,
  input logic        clk_en_out,
  input logic        sel_tick
);
  a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_wr && wr_unlock) && !(sleep_in && wake_evt)) |=> $stable(reg_rdata));

  a_r4_wake_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_in && wake_evt && reg_rdata[15]) |=>
      (reg_rdata[1:0] == $past(reg_rdata[9:8]) && reg_rdata[5:4] == $past(reg_rdata[13:12])));

  a_r5_no_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && !reg_rdata[15] && !(reg_wr && wr_unlock)) |=> $stable(reg_rdata));

  a_r8_err_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |-> is_reserved(reg_rdata[1:0], reg_rdata[5:4]));

  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    src_req[reg_rdata[1:0]] && src_req[use_src]);

  a_r10_wait_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (use_src != reg_rdata[1:0] && !src_ready[reg_rdata[1:0]]) |=> $stable(use_src));

  a_r11_pulse_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_out |-> $past(sel_tick));
endmodule

bind sysclk_sel sysclk_sel_chk i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .wr_unlock(wr_unlock),
  .sleep_in(sleep_in), .wake_evt(wake_evt), .reg_rdata(reg_rdata),
  .src_ready(src_ready), .src_req(src_req), .use_src(use_src),
  .div_err(div_err), .clk_en_out(clk_en_out), .sel_tick(sel_tick)
);

// File: tb/test_sysclk_sel.sv
`timescale 1ns/1ps
module test_sysclk_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        wr_unlock = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        sleep_in = 1'b0;
  logic        wake_evt = 1'b0;
  logic [3:0]  src_tick = '0;
  logic [3:0]  src_ready = 4'b0001;
  logic [3:0]  src_req;
  logic [1:0]  use_src;
  logic        div_err;
  logic        clk_en_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  sysclk_sel i_sysclk_sel (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .wr_unlock(wr_unlock),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sleep_in(sleep_in),
    .wake_evt(wake_evt), .src_tick(src_tick), .src_ready(src_ready),
    .src_req(src_req), .use_src(use_src), .div_err(div_err),
    .clk_en_out(clk_en_out)
  );

  always #5 clk = ~clk;

  // Tick periods in core cycles for sources 0..3
  initial begin
    int ph [4];
    int per [4];
    per[0] = 2; per[1] = 5; per[2] = 1; per[3] = 3;
    for (int i = 0; i < 4; i++) ph[i] = 0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        src_tick[i] = (ph[i] == 0);
        ph[i] = (ph[i] + 1 == per[i]) ? 0 : ph[i] + 1;
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !done) begin
        checks++; errors++;
        $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc);
        summary();
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int tick_per(input int s);
    case (s)
      0: return 2;
      1: return 5;
      2: return 1;
      default: return 3;
    endcase
  endfunction

  function automatic int ratio_of(input int s, input int d);
    case (s)
      0: return 1 << d;
      1: return (d == 1) ? 2 : 1;
      2: begin
        int t [4];
        t[0] = 1; t[1] = 2; t[2] = 8; t[3] = 16;
        return t[d];
      end
      default: return 1;
    endcase
  endfunction

  task automatic write(input logic [15:0] v, input logic unl);
    reg_wr = 1'b1; reg_wdata = v; wr_unlock = unl;
    @(negedge clk);
    reg_wr = 1'b0; wr_unlock = 1'b0;
  endtask

  task automatic wake(input logic slp);
    sleep_in = slp; wake_evt = 1'b1;
    @(negedge clk);
    sleep_in = 1'b0; wake_evt = 1'b0;
  endtask

  task automatic gap(input string req, input int s, input int d);
    int n = 0;
    repeat (40) @(negedge clk);
    while (!clk_en_out && n < 200) begin @(negedge clk); n++; end
    n = 0;
    @(negedge clk);
    while (!clk_en_out && n < 200) begin @(negedge clk); n++; end
    chk(req, n + 1, ratio_of(s, d) * tick_per(s));
  endtask

  task automatic t_reset();
    chk("R2 reset word", reg_rdata, 16'h0020);
    chk("R2 reset use_src", use_src, 0);
    chk("R2 reset div_err", div_err, 0);
    chk("R9 reset req", src_req, 4'b0001);
    gap("R11 reset ratio", 0, 2);
  endtask

  task automatic t_lock();
    write(16'h0031, 1'b0);
    chk("R3 locked write dropped", reg_rdata, 16'h0020);
    gap("R3 locked ratio kept", 0, 2);
  endtask

  task automatic t_int();
    write(16'h0030, 1'b1);
    chk("R3 unlocked write", reg_rdata, 16'h0030);
    gap("R7 int 1/8", 0, 3);
    write(16'h0000, 1'b1);
    gap("R7 int 1/1", 0, 0);
  endtask

  task automatic t_high();
    src_ready[2] = 1'b1;
    write(16'h0022, 1'b1);
    @(negedge clk);
    chk("R10 switch when ready", use_src, 2);
    gap("R7 high 1/8", 2, 2);
    write(16'h0032, 1'b1);
    gap("R7 high 1/16", 2, 3);
    write(16'h0012, 1'b1);
    gap("R7 high 1/2", 2, 1);
  endtask

  task automatic t_pend();
    write(16'h0003, 1'b1);
    chk("R9 request for stopped source", src_req, 4'b1100);
    repeat (5) @(negedge clk);
    chk("R10 hold old source", use_src, 2);
    gap("R10 old ratio kept", 2, 1);
    src_ready[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 switch after ready", use_src, 3);
    chk("R9 request after switch", src_req, 4'b1000);
    gap("R7 ext 1/1", 3, 0);
  endtask

  task automatic t_rsv();
    src_ready[1] = 1'b1;
    write(16'h0021, 1'b1);
    chk("R8 err raised", div_err, 1);
    @(negedge clk);
    chk("R8 err one cycle", div_err, 0);
    gap("R8 reserved low as 1/1", 1, 0);
    write(16'hFFFF, 1'b1);
    chk("R1 reserved bits zero", reg_rdata, 16'hB333);
    chk("R8 err ext", div_err, 1);
    gap("R8 reserved ext as 1/1", 3, 0);
    write(16'h0011, 1'b1);
    chk("R8 legal no err", div_err, 0);
    gap("R7 low 1/2", 1, 1);
  endtask

  task automatic t_wake_on();
    write(16'h9201, 1'b1);
    wake(1'b1);
    chk("R4 reload applied", reg_rdata, 16'h9212);
    gap("R4 reloaded ratio", 2, 1);
  endtask

  task automatic t_wake_off();
    write(16'h9201, 1'b1);
    wake(1'b0);
    chk("R5 no reload while awake", reg_rdata, 16'h9201);
    write(16'h1201, 1'b1);
    wake(1'b1);
    chk("R5 no reload when disabled", reg_rdata, 16'h1201);
    gap("R5 ratio unchanged", 1, 0);
  endtask

  task automatic t_collide();
    write(16'h8201, 1'b1);
    reg_wr = 1'b1; wr_unlock = 1'b1; reg_wdata = 16'h0013;
    sleep_in = 1'b1; wake_evt = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; wr_unlock = 1'b0; sleep_in = 1'b0; wake_evt = 1'b0;
    chk("R6 reload wins over write", reg_rdata, 16'h8202);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_int();
    t_high();
    t_pend();
    t_rsv();
    t_wake_on();
    t_wake_off();
    t_collide();
    done = 1'b1;
    summary();
  end
endmodule